// File: doc/BRIEF.md
# Eight-Pin GPIO Port with Interrupt Detection

This block is an eight-pin general-purpose I/O port behind a simple byte-wide register interface. Software picks per pin whether it is driven or sampled, writes the value driven on output pins, and reads back the level of every pin. The input side passes through a two-flop synchronizer. An optional per-pin debounce filter then rejects short pulses.

Each pin can also act as an interrupt source. Two configuration bits per pin choose the trigger. The first picks level or edge sensitivity. The second picks the polarity: low or falling, versus high or rising. Edge events are held in a sticky bit until software writes a one to that pin's position in the acknowledge register. Level events simply follow the input. A per-pin enable gates every source. The gated sources are visible in a read-only status register, and their OR drives a single interrupt output.

The register offsets are fixed, because software decodes them. All outputs, including the read data, are registered.

Top module: `pio8_irq`

## Requirements
- R1: While reset is high, and after it, every register holds 0: all pins are inputs (pad_oe = 0x00), pad_out = 0x00, and irq is low. Reset is synchronous and active high.
- R2: Direction register at offset 0x10: a bit of 1 makes that pin an output (pad_oe bit 1), and a bit of 0 makes it an input. pad_oe follows a write on the next clock.
- R3: Data register at offset 0x00: a write sets pad_out on the next clock. A read returns the written bit for output pins and the synchronized pad level for input pins.
- R4: Level mode is selected by a 0 in the mode register (offset 0x90). The status bit follows the (possibly filtered) input. The polarity register (offset 0x94) selects the active level: 1 means active high and 0 means active low. Level events are not latched.
- R5: Edge mode is selected by a 1 in the mode register. Polarity 1 detects a rising edge and polarity 0 detects a falling edge. A detected edge sets a sticky pending bit.
- R6: Acknowledge register at offset 0x98 (write only): a 1 clears that pin's sticky edge bit, and a 0 leaves it unchanged. A write has no lasting effect on a level source that is still active.
- R7: Enable register at offset 0x9C: a pin whose enable bit is 0 shows no status. Edges that occur while the pin is disabled are not remembered.
- R8: The status register at offset 0xA0 (read only) holds one bit per pending, enabled source. irq is 1 exactly when the status is non-zero.
- R9: Debounce register at offset 0xA8: when a pin's bit is 1, its interrupt input changes only after the synchronized pad has held a new value for 4 consecutive clocks, so shorter pulses are ignored. When the bit is 0, the synchronized pad is used directly.
- R10: Reads return read data one clock after rd_en, and read data holds otherwise. Reads of unmapped offsets return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Register byte offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| pad_in | input | 8 | Asynchronous pin levels |
| pad_out | output | 8 | Value driven on output pins |
| pad_oe | output | 8 | Output enable per pin (1 = output) |
| irq | output | 1 | Combined interrupt |

## Verification
On every cycle, the assertions check three things: the quiet state after reset, that the direction and data writes reach pad_oe and pad_out one clock later, and that irq agrees with the status register. They also check that no status bit is set for a pin that was disabled in the cycle before. Some behaviours need a chosen sequence of stimulus, and only the bench scenarios show them. These are the sticky edge bit and its selective clearing, the non-latched level path, the pulse rejection of the debounce filter against the raw path, and the read-back mix of driven and sampled levels.

// File: rtl/pio_pkg.sv
package pio_pkg;
  parameter int OFS_W = 8;
  parameter logic [OFS_W-1:0] OFS_DATA = 8'h00;
  parameter logic [OFS_W-1:0] OFS_DIR  = 8'h10;
  parameter logic [OFS_W-1:0] OFS_MODE = 8'h90;
  parameter logic [OFS_W-1:0] OFS_POL  = 8'h94;
  parameter logic [OFS_W-1:0] OFS_ACK  = 8'h98;
  parameter logic [OFS_W-1:0] OFS_IEN  = 8'h9C;
  parameter logic [OFS_W-1:0] OFS_STAT = 8'hA0;
  parameter logic [OFS_W-1:0] OFS_DEB  = 8'hA8;

  typedef enum logic {TRIG_LEVEL = 1'b0, TRIG_EDGE = 1'b1} trig_e;
endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] ff;

  always_ff @(posedge clk) begin
    if (rst) begin
      ff <= '0;
    end else begin
      ff[0] <= d;
      for (int s = 1; s < STAGES; s++) ff[s] <= ff[s-1];
    end
  end

  assign q = ff[STAGES-1];
endmodule

// File: rtl/pio_debounce.sv
module pio_debounce #(
  parameter int W    = 8,
  parameter int HOLD = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int CW = (HOLD > 1) ? $clog2(HOLD) : 1;
  localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic [CW-1:0] cnt;
    logic          filt;

    always_ff @(posedge clk) begin
      if (rst) begin
        cnt  <= '0;
        filt <= 1'b0;
      end else if (d[i] == filt) begin
        cnt <= '0;
      end else if (cnt == LAST) begin
        cnt  <= '0;
        filt <= d[i];
      end else begin
        cnt <= cnt + 1'b1;
      end
    end

    assign q[i] = filt;
  end
endmodule

// File: rtl/pio_irq_detect.sv
module pio_irq_detect
  import pio_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] smp,
  input  logic [W-1:0] mode,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] ien,
  input  logic [W-1:0] ack,
  output logic [W-1:0] status,
  output logic         irq
);
  logic [W-1:0] prev;
  logic [W-1:0] sticky;
  logic [W-1:0] src;

  for (genvar i = 0; i < W; i++) begin : g_src
    logic hit_edge;
    logic hit_level;

    assign hit_level = pol[i] ? smp[i] : ~smp[i];
    assign hit_edge  = pol[i] ? (smp[i] & ~prev[i]) : (~smp[i] & prev[i]);

    always_ff @(posedge clk) begin
      if (rst) begin
        sticky[i] <= 1'b0;
      end else if (!ien[i] || trig_e'(mode[i]) == TRIG_LEVEL) begin
        sticky[i] <= 1'b0;
      end else begin
        sticky[i] <= (sticky[i] & ~ack[i]) | hit_edge;
      end
    end

    assign src[i] = ien[i] &
                    ((trig_e'(mode[i]) == TRIG_EDGE) ? ((sticky[i] & ~ack[i]) | hit_edge)
                                                     : hit_level);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev   <= '0;
      status <= '0;
      irq    <= 1'b0;
    end else begin
      prev   <= smp;
      status <= src;
      irq    <= |src;
    end
  end
endmodule

// File: rtl/pio8_irq.sv
module pio8_irq
  import pio_pkg::*;
#(
  parameter int N_PINS      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int DEB_HOLD    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [OFS_W-1:0]  addr,
  input  logic [N_PINS-1:0] wdata,
  output logic [N_PINS-1:0] rdata,
  input  logic [N_PINS-1:0] pad_in,
  output logic [N_PINS-1:0] pad_out,
  output logic [N_PINS-1:0] pad_oe,
  output logic              irq
);
  logic [N_PINS-1:0] dout_q, dir_q, mode_q, pol_q, ien_q, deb_q;
  logic [N_PINS-1:0] sync_lvl, filt_lvl, det_in, ack_vec, status_q, rd_mux;

  pio_sync #(.W(N_PINS), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .d(pad_in), .q(sync_lvl));

  pio_debounce #(.W(N_PINS), .HOLD(DEB_HOLD)) deb_i (
    .clk(clk), .rst(rst), .d(sync_lvl), .q(filt_lvl));

  assign det_in  = (deb_q & filt_lvl) | (~deb_q & sync_lvl);
  assign ack_vec = (wr_en && addr == OFS_ACK) ? wdata : '0;

  pio_irq_detect #(.W(N_PINS)) det_i (
    .clk(clk), .rst(rst), .smp(det_in), .mode(mode_q), .pol(pol_q),
    .ien(ien_q), .ack(ack_vec), .status(status_q), .irq(irq));

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_q <= '0;
      dir_q  <= '0;
      mode_q <= '0;
      pol_q  <= '0;
      ien_q  <= '0;
      deb_q  <= '0;
    end else if (wr_en) begin
      case (addr)
        OFS_DATA: dout_q <= wdata;
        OFS_DIR:  dir_q  <= wdata;
        OFS_MODE: mode_q <= wdata;
        OFS_POL:  pol_q  <= wdata;
        OFS_IEN:  ien_q  <= wdata;
        OFS_DEB:  deb_q  <= wdata;
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      OFS_DATA: rd_mux = (dir_q & dout_q) | (~dir_q & sync_lvl);
      OFS_DIR:  rd_mux = dir_q;
      OFS_MODE: rd_mux = mode_q;
      OFS_POL:  rd_mux = pol_q;
      OFS_IEN:  rd_mux = ien_q;
      OFS_STAT: rd_mux = status_q;
      OFS_DEB:  rd_mux = deb_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  assign pad_out = dout_q;
  assign pad_oe  = dir_q;
endmodule

// File: rtl/pio8_irq_chk.sv
module pio8_irq_chk
  import pio_pkg::*;
#(
  parameter int N = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [OFS_W-1:0] addr,
  input logic [N-1:0]     wdata,
  input logic [N-1:0]     pad_out,
  input logic [N-1:0]     pad_oe,
  input logic             irq,
  input logic [N-1:0]     ien_q,
  input logic [N-1:0]     status_q
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (pad_oe == '0 && pad_out == '0 && irq == 1'b0));

  p_dir_drives_oe_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == OFS_DIR) |=> pad_oe == $past(wdata));

  p_data_drives_out_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == OFS_DATA) |=> pad_out == $past(wdata));

  p_gate_r7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (status_q & ~$past(ien_q)) == '0);

  p_irq_or_r8: assert property (@(posedge clk) disable iff (rst)
    irq == (status_q != '0));
endmodule

bind pio8_irq pio8_irq_chk #(.N(N_PINS)) chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq),
  .ien_q(ien_q), .status_q(status_q));

// File: tb/pio8_irq_tb_top.sv
module pio8_irq_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] addr = '0, wdata = '0, pad_in = '0;
  logic [7:0] rdata, pad_out, pad_oe;
  logic       irq;
  int         n_chk = 0, n_err = 0, cyc = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  pio8_irq dut_i (.clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .irq(irq));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: run hung, actual=%0d expected<100000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic quiesce();
    wr(8'h9C, 8'h00); wr(8'hA8, 8'h00); wr(8'h98, 8'hFF); idle(3);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 pad_oe", pad_oe, 8'h00);
    chk("R1 pad_out", pad_out, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);
    rd(8'h9C, v); chk("R1 enable reg", v, 8'h00);
    rd(8'hA0, v); chk("R1 status", v, 8'h00);
  endtask

  task automatic t_dir_data();
    logic [7:0] v;
    wr(8'h10, 8'h0F); chk("R2 pad_oe", pad_oe, 8'h0F);
    wr(8'h00, 8'hA5); chk("R3 pad_out", pad_out, 8'hA5);
    pad_in = 8'h30; idle(4);
    rd(8'h00, v); chk("R3 data readback mix", v, 8'h35);
    rd(8'h10, v); chk("R2 dir readback", v, 8'h0F);
    rd(8'h5C, v); chk("R10 unmapped read", v, 8'h00);
    wr(8'h10, 8'h00); chk("R2 back to inputs", pad_oe, 8'h00);
    pad_in = 8'h00; idle(4);
  endtask

  task automatic t_level();
    logic [7:0] v;
    quiesce();
    wr(8'h90, 8'h00); wr(8'h94, 8'h01); wr(8'h9C, 8'h03);
    pad_in = 8'h03; idle(6);
    rd(8'hA0, v); chk("R4 level high/low active", v, 8'h01);
    chk("R8 irq with status", {7'b0, irq}, 8'h01);
    pad_in = 8'h00; idle(6);
    rd(8'hA0, v); chk("R4 level not latched", v, 8'h02);
    wr(8'h98, 8'h02); idle(3);
    rd(8'hA0, v); chk("R6 ack on active level", v, 8'h02);
    wr(8'h9C, 8'h00); idle(3);
    rd(8'hA0, v); chk("R7 disabled level", v, 8'h00);
    chk("R8 irq low", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_edge();
    logic [7:0] v;
    quiesce();
    wr(8'h90, 8'h0C); wr(8'h94, 8'h04); pad_in = 8'h08; idle(6);
    wr(8'h9C, 8'h0C);
    pad_in = 8'h0C; idle(6); pad_in = 8'h08; idle(6);
    rd(8'hA0, v); chk("R5 rising sticky", v, 8'h04);
    wr(8'h98, 8'h08); idle(3);
    rd(8'hA0, v); chk("R6 zero bits unaffected", v, 8'h04);
    wr(8'h98, 8'h04); idle(3);
    rd(8'hA0, v); chk("R6 ack clears edge", v, 8'h00);
    pad_in = 8'h00; idle(6);
    rd(8'hA0, v); chk("R5 falling edge", v, 8'h08);
    wr(8'h98, 8'h08); wr(8'h9C, 8'h00);
    pad_in = 8'h04; idle(6); pad_in = 8'h00; idle(6);
    wr(8'h9C, 8'h0C); idle(3);
    rd(8'hA0, v); chk("R7 edges while disabled lost", v, 8'h00);
  endtask

  task automatic t_debounce();
    logic [7:0] v;
    quiesce();
    wr(8'h90, 8'h10); wr(8'h94, 8'h10); wr(8'hA8, 8'h10); idle(8);
    wr(8'h9C, 8'h10);
    pad_in = 8'h10; idle(2); pad_in = 8'h00; idle(10);
    rd(8'hA0, v); chk("R9 short pulse rejected", v, 8'h00);
    pad_in = 8'h10; idle(10);
    rd(8'hA0, v); chk("R9 held input passes", v, 8'h10);
    pad_in = 8'h00; idle(10);
    wr(8'hA8, 8'h00); wr(8'h98, 8'h10); idle(3);
    pad_in = 8'h10; idle(2); pad_in = 8'h00; idle(8);
    rd(8'hA0, v); chk("R9 raw path sees pulse", v, 8'h10);
    wr(8'h98, 8'h10); idle(3);
  endtask

  initial begin
    idle(4); rst = 1'b0; idle(2);
    t_reset();
    t_dir_data();
    t_level();
    t_edge();
    t_debounce();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule